// File: doc/BRIEF.md
# PWM Input Pulse Measurer

This block measures a pulse-width-modulated signal. A 3-bit select picks one of eight candidate inputs. The chosen signal passes through a two-flop synchroniser and an edge detector. Three results come out, all counted in clock ticks of 10 ns. The first is the length of the most recent complete high phase. The second is the length of the most recent complete low phase. The third is a live count of the ticks since the last edge of either polarity.

One instance serves every PWM channel of the chip, so all channels read the same selected source. The three results are read-only register values that are valid on every cycle. They carry no handshake and need no back-pressure: a reader samples them whenever it wants, and a value stays put until the next edge or the next change of source. Changing the select wipes all results. The block then waits until the synchroniser holds only the new source before it accepts any edge.

Top module: `pwm_pulse_meter`

## Requirements
- R1: While reset is asserted (rst_n low), high_len, low_len and since_edge all read zero.
- R2: Only src_in bit number src_sel is measured. Activity on any other bit of src_in changes no output.
- R3: On a falling edge of the synchronised input, high_len takes the number of clock cycles the input was sampled high.
- R4: On a rising edge of the synchronised input, low_len takes the number of clock cycles the input was sampled low.
- R5: since_edge counts the cycles since the last detected edge. An input change first sampled at clock edge k makes since_edge read 1 after edge k+2, and the value then grows by one per cycle.
- R6: since_edge saturates at all-ones (2^CNT_W-1) instead of wrapping.
- R7: A phase longer than the counter range is reported as all-ones in high_len or low_len.
- R8: A change of src_sel sampled at clock edge c sets all three results to zero after edge c. since_edge stays zero through edge c+2 and reads n-3 after n edges, counting edge c as the first. Switching between sources at different levels records no edge.
- R9: high_len and low_len change only at a detected edge or at a source change. Each keeps its value between those events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per 10 ns |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Index of the measured src_in bit |
| src_in | input | 8 | Candidate PWM inputs, asynchronous |
| high_len | output | 32 | Length of the latest complete high phase, in ticks |
| low_len | output | 32 | Length of the latest complete low phase, in ticks |
| since_edge | output | 32 | Ticks since the last detected edge, saturating |

## Verification
Saturation is the hardest case to reach from the ports. With 32-bit counters it needs more than four billion idle cycles. The bench therefore adds a second instance with CNT_W set to 6. It holds that instance's input still until since_edge saturates, then toggles the input so that the saturated count lands in low_len and high_len. The spurious edge a source switch could cause is also hard to reach. The bench brings it about by switching from an input held low to an input held high, then confirming that both phase results stay at zero.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } pwm_edge_t;
endpackage

// File: rtl/pwm_sel_guard.sv
module pwm_sel_guard #(
  parameter int SEL_W = 3,
  parameter int SYNC_STAGES = 2,
  localparam int BW = $clog2(SYNC_STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_changed,
  output logic             blanking
);
  logic [SEL_W-1:0] sel_q;
  logic [BW-1:0]    blank_cnt;

  assign sel_changed = (sel != sel_q);
  assign blanking    = (blank_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      blank_cnt <= BW'(SYNC_STAGES);
    end else begin
      sel_q <= sel;
      if (sel_changed)
        blank_cnt <= BW'(SYNC_STAGES);
      else if (blanking)
        blank_cnt <= blank_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pwm_src_sync.sv
module pwm_src_sync
  import pwm_meas_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SEL_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] src,
  input  logic             suppress,
  output pwm_edge_t        ev
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  assign raw = src[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= raw;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[SYNC_STAGES-1];
  end

  always_comb begin
    ev.rise = !suppress &&  chain[SYNC_STAGES-1] && !prev;
    ev.fall = !suppress && !chain[SYNC_STAGES-1] &&  prev;
  end
endmodule

// File: rtl/pwm_run_counter.sv
module pwm_run_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (zero)
      count <= '0;
    else if (restart)
      count <= CNT_W'(1);
    else if (count != TOP)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/pwm_phase_latch.sv
module pwm_phase_latch #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             capture,
  input  logic [CNT_W-1:0] value,
  output logic [CNT_W-1:0] result
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result <= '0;
    else if (clear)   result <= '0;
    else if (capture) result <= value;
  end
endmodule

// File: rtl/pwm_pulse_meter.sv
module pwm_pulse_meter
  import pwm_meas_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int CNT_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [N_SRC-1:0] src_in,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] since_edge
);
  logic      sel_changed;
  logic      blanking;
  pwm_edge_t ev;

  pwm_sel_guard #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_guard (
    .clk(clk), .rst_n(rst_n), .sel(src_sel),
    .sel_changed(sel_changed), .blanking(blanking)
  );

  pwm_src_sync #(.N_SRC(N_SRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sel(src_sel), .src(src_in),
    .suppress(sel_changed || blanking), .ev(ev)
  );

  pwm_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .zero(sel_changed || blanking),
    .restart(ev.rise || ev.fall), .count(since_edge)
  );

  pwm_phase_latch #(.CNT_W(CNT_W)) u_high (
    .clk(clk), .rst_n(rst_n), .clear(sel_changed),
    .capture(ev.fall), .value(since_edge), .result(high_len)
  );

  pwm_phase_latch #(.CNT_W(CNT_W)) u_low (
    .clk(clk), .rst_n(rst_n), .clear(sel_changed),
    .capture(ev.rise), .value(since_edge), .result(low_len)
  );
endmodule

// File: rtl/pwm_pulse_meter_chk.sv
module pwm_pulse_meter_chk #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] src_sel,
  input logic [CNT_W-1:0] high_len,
  input logic [CNT_W-1:0] low_len,
  input logic [CNT_W-1:0] since_edge
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (src_sel != $past(src_sel)) |=> (high_len == '0 && low_len == '0 && since_edge == '0)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (since_edge != '0 && since_edge != MAXV) |=> (since_edge == $past(since_edge) + 1'b1 || since_edge <= CNT_W'(1))); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (since_edge == MAXV) |=> (since_edge == MAXV || since_edge <= CNT_W'(1))); // R6
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$stable(high_len) |-> (since_edge <= CNT_W'(1))); // R9
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$stable(low_len) |-> (since_edge <= CNT_W'(1))); // R9
  AST_HIGH_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!$stable(high_len) && since_edge == CNT_W'(1)) |-> (high_len == $past(since_edge))); // R3
  AST_LOW_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!$stable(low_len) && since_edge == CNT_W'(1)) |-> (low_len == $past(since_edge))); // R4
endmodule

bind pwm_pulse_meter pwm_pulse_meter_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
  .high_len(high_len), .low_len(low_len), .since_edge(since_edge)
);

// File: tb/sim_pwm_pulse_meter.sv
module sim_pwm_pulse_meter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{3, 5}, '{1, 1}, '{7, 2}, '{12, 4}, '{2, 9}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [7:0]  in_bus = 8'd0;
  logic [7:0]  in1 = 8'd0;
  logic [31:0] hi0, lo0, se0;
  logic [5:0]  hi1, lo1, se1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_pulse_meter u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(sel), .src_in(in_bus),
    .high_len(hi0), .low_len(lo0), .since_edge(se0)
  );

  pwm_pulse_meter #(.CNT_W(6)) u1 (
    .clk(clk), .rst_n(rst_n), .src_sel(3'd0), .src_in(in1),
    .high_len(hi1), .low_len(lo1), .since_edge(se1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int bit_idx, input logic v, input int n);
    in_bus[bit_idx] = v;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold1(input logic v, input int n);
    in1[0] = v;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 high_len in reset", hi0, 0);
    check("R1 low_len in reset", lo0, 0);
    check("R1 since_edge in reset", se0, 0);
    rst_n = 1'b1;
    hold(0, 1'b0, 5);

    for (int i = 0; i < NV; i++) begin
      hold(0, 1'b1, VEC[i][0]);
      hold(0, 1'b0, VEC[i][1]);
      hold(0, 1'b1, 3);
      check("R3 high phase length", hi0, VEC[i][0]);
      check("R4 low phase length", lo0, VEC[i][1]);
      if (i == 0) check("R5 since_edge one after edge", se0, 1);
      hold(0, 1'b0, 4);
    end

    in_bus[2] = 1'b1;
    repeat (10) begin
      in_bus[1] = ~in_bus[1];
      in_bus[3] = ~in_bus[3];
      @(posedge clk);
      @(negedge clk);
    end
    check("R2 unselected bits leave since_edge counting", se0, 12);
    check("R2 high_len unchanged", hi0, 3);
    check("R9 low_len held between edges", lo0, VEC[NV-1][1]);

    in_bus[1] = 1'b0;
    in_bus[3] = 1'b0;
    sel = 3'd2;
    @(posedge clk);
    @(negedge clk);
    check("R8 high_len cleared", hi0, 0);
    check("R8 low_len cleared", lo0, 0);
    check("R8 since_edge cleared", se0, 0);
    repeat (9) @(posedge clk);
    @(negedge clk);
    check("R8 since_edge restarts after blanking", se0, 7);
    check("R8 no spurious low capture", lo0, 0);
    check("R8 no spurious high capture", hi0, 0);

    check("R6 since_edge saturates", {26'd0, se1}, 63);
    hold1(1'b1, 3);
    check("R7 low_len saturated", {26'd0, lo1}, 63);
    check("R5 since_edge after edge", {26'd0, se1}, 1);
    hold1(1'b1, 70);
    check("R6 since_edge stays saturated", {26'd0, se1}, 63);
    hold1(1'b0, 3);
    check("R7 high_len saturated", {26'd0, hi1}, 63);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule